// File: doc/BRIEF.md
# Dual-Space Access Guard

This block judges every memory request in a machine that keeps instructions and data in two separate address spaces. A processor request names its target space, its kind of access (fetch, read or write), the current privilege level and an address. The guard answers with grant or fault and a cause code. A second, independent port judges DMA writes from device controllers. Both answers are registered and appear one clock after the request.

Protection depends mainly on which space a request targets, not on per-page permission bits. Instruction space holds the operating system image in a write-locked window. It also holds a read-write window for stacks and a window for peripheral, I/O and memory-management registers. Only kernel code may touch instruction space. Data space is open to ordinary reads and writes, and to user-level fetches. DMA may only land in data space.

The three instruction-space windows have inclusive bounds. These bounds are loaded through a setup port that obeys only kernel-level writes, and only until a sticky lock is set. A reset clears the lock.

Top module: `space_guard`

## Requirements
- R1: After reset all response outputs are 0, the lock is clear and all three windows are empty (low bound all ones, high bound 0), so any kernel access to instruction space faults with cause 5.
- R2: A response is due one clock after its request. A cycle with `cpu_valid` or `dma_valid` low gives valid, grant, fault and cause all 0 on that port in the next cycle.
- R3: With `cpu_space`=1 (data), a read (`cpu_access`=1) or write (`cpu_access`=2 or 3) is granted at either privilege. A fetch (`cpu_access`=0) with `cpu_kernel`=0 is also granted.
- R4: A data-space fetch with `cpu_kernel`=1 faults with cause 3.
- R5: A write (`cpu_access` 2 or 3) to instruction space (`cpu_space`=0) at an address inside the OS window (`cfg_sel`=0) faults with cause 1 at either privilege. This rule takes priority over R6 and R8.
- R6: Any other instruction-space request with `cpu_kernel`=0 faults with cause 2. This covers fetch, read and write.
- R7: A kernel instruction-space request inside the OS, stack (`cfg_sel`=1) or peripheral (`cfg_sel`=2) window is granted, unless R5 applies. Bounds are inclusive.
- R8: A kernel instruction-space request whose address lies in no window faults with cause 5.
- R9: A DMA request with `dma_space`=1 is granted. One with `dma_space`=0 faults with cause 4. The DMA port is judged in the same cycle as a processor request, independently of it.
- R10: A window update (`cfg_we`, `cfg_sel` < 3) takes effect on the next clock, and only when `cfg_kernel`=1 and the guard is not locked. `cfg_lock` with `cfg_kernel`=1 sets the lock; a write in that same cycle still lands. Once set, the lock holds until reset and later updates are ignored.
- R11: Grant and fault are never both 1 on a port. Fault is 1 exactly when the cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Window update strobe |
| cfg_kernel | input | 1 | Privilege of the setup access, 1 = kernel |
| cfg_sel | input | 2 | Window to update: 0 OS, 1 stack, 2 peripheral |
| cfg_lo | input | 16 | New inclusive low bound |
| cfg_hi | input | 16 | New inclusive high bound |
| cfg_lock | input | 1 | Request to freeze the windows |
| cpu_valid | input | 1 | Processor request present |
| cpu_space | input | 1 | 0 instruction space, 1 data space |
| cpu_access | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as write |
| cpu_kernel | input | 1 | 1 = kernel privilege |
| cpu_addr | input | 16 | Request address |
| dma_valid | input | 1 | DMA write present |
| dma_space | input | 1 | 0 instruction space, 1 data space |
| cpu_rsp_valid | output | 1 | Processor response present |
| cpu_rsp_grant | output | 1 | Processor request allowed |
| cpu_rsp_fault | output | 1 | Processor request refused |
| cpu_rsp_cause | output | 3 | Processor fault cause |
| dma_rsp_valid | output | 1 | DMA response present |
| dma_rsp_grant | output | 1 | DMA write allowed |
| dma_rsp_fault | output | 1 | DMA write refused |
| dma_rsp_cause | output | 3 | DMA fault cause |

## Verification
Both result ports are due exactly one clock after the request that caused them. A window update or lock becomes visible only to requests made on the next clock or later. The bench drives each stimulus just after a rising edge and computes the expected answer from the window bounds that were in force before that edge. It compares both ports one time unit after the following rising edge. Ignored setup writes are checked by probing addresses that would have moved into or out of a window if the write had landed.

// File: rtl/space_guard_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the dual-space access guard.
// Assumes two address spaces of equal address width and three
// instruction-space windows in a fixed order (OS, stack, peripheral).
package space_guard_pkg;

    typedef enum logic {
        SPACE_INSTR = 1'b0,
        SPACE_DATA  = 1'b1
    } space_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [2:0] {
        CAUSE_NONE        = 3'd0,
        CAUSE_LOCKED_WR   = 3'd1,
        CAUSE_USER_ISPACE = 3'd2,
        CAUSE_KERN_DFETCH = 3'd3,
        CAUSE_DMA_ISPACE  = 3'd4,
        CAUSE_NO_WINDOW   = 3'd5
    } cause_e;

    localparam int WIN_CNT    = 3;
    localparam int WIN_OS     = 0;
    localparam int WIN_STACK  = 1;
    localparam int WIN_PERIPH = 2;
    localparam int SEL_W      = $clog2(WIN_CNT);

    typedef struct packed {
        logic   grant;
        logic   fault;
        cause_e cause;
    } verdict_t;

endpackage

// File: rtl/sg_window_bank.sv
`timescale 1ns/1ps
// Holds the inclusive bounds of the instruction-space windows and the
// one-way setup lock. Assumes updates come from kernel code during
// boot; once the lock is set only a reset reopens the bank.
module sg_window_bank
    import space_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_kernel,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [ADDR_W-1:0]         cfg_lo,
    input  logic [ADDR_W-1:0]         cfg_hi,
    input  logic                      cfg_lock,
    output logic [ADDR_W-1:0]         win_lo [WIN_CNT],
    output logic [ADDR_W-1:0]         win_hi [WIN_CNT],
    output logic                      locked
);

    logic open_write;
    assign open_write = cfg_kernel && !locked;

    // Sticky lock: set by a kernel request, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (cfg_lock && open_write)
            locked <= 1'b1;
    end

    for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
        // Per-window bound register, empty after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_lo[w] <= '1;
                win_hi[w] <= '0;
            end else if (cfg_we && open_write && cfg_sel == SEL_W'(w)) begin
                win_lo[w] <= cfg_lo;
                win_hi[w] <= cfg_hi;
            end
        end
    end

endmodule

// File: rtl/sg_window_match.sv
`timescale 1ns/1ps
// Inclusive range compare of one address against every window.
// Purely combinational; a window whose low bound exceeds its high
// bound never matches.
module sg_window_match
    import space_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] win_lo [WIN_CNT],
    input  logic [ADDR_W-1:0] win_hi [WIN_CNT],
    output logic [WIN_CNT-1:0] hit
);

    for (genvar w = 0; w < WIN_CNT; w++) begin : g_cmp
        assign hit[w] = (addr >= win_lo[w]) && (addr <= win_hi[w]);
    end

endmodule

// File: rtl/sg_cpu_rules.sv
`timescale 1ns/1ps
// Decides the verdict for a processor request from its space, access
// kind, privilege and window hits. Priority: kernel data fetch,
// locked-window write, user instruction access, no window, grant.
module sg_cpu_rules
    import space_guard_pkg::*;
(
    input  logic               space,
    input  logic [1:0]         access,
    input  logic               kernel,
    input  logic [WIN_CNT-1:0] hit,
    output verdict_t           verdict
);

    logic is_write;
    logic is_fetch;
    assign is_write = (access_e'(access) == ACC_WRITE) || (access_e'(access) == ACC_RSVD);
    assign is_fetch = (access_e'(access) == ACC_FETCH);

    // Rule ladder for one processor request.
    always_comb begin
        verdict = '{grant: 1'b0, fault: 1'b1, cause: CAUSE_NONE};
        if (space_e'(space) == SPACE_DATA) begin
            if (is_fetch && kernel)
                verdict.cause = CAUSE_KERN_DFETCH;
            else
                verdict = '{grant: 1'b1, fault: 1'b0, cause: CAUSE_NONE};
        end else if (is_write && hit[WIN_OS]) begin
            verdict.cause = CAUSE_LOCKED_WR;
        end else if (!kernel) begin
            verdict.cause = CAUSE_USER_ISPACE;
        end else if (hit == '0) begin
            verdict.cause = CAUSE_NO_WINDOW;
        end else begin
            verdict = '{grant: 1'b1, fault: 1'b0, cause: CAUSE_NONE};
        end
    end

endmodule

// File: rtl/sg_dma_rules.sv
`timescale 1ns/1ps
// Verdict for a device DMA write: only data space may be written.
// Assumes every DMA request is a write.
module sg_dma_rules
    import space_guard_pkg::*;
(
    input  logic     space,
    output verdict_t verdict
);

    // Single rule: instruction-space targets are refused.
    always_comb begin
        if (space_e'(space) == SPACE_DATA)
            verdict = '{grant: 1'b1, fault: 1'b0, cause: CAUSE_NONE};
        else
            verdict = '{grant: 1'b0, fault: 1'b1, cause: CAUSE_DMA_ISPACE};
    end

endmodule

// File: rtl/space_guard.sv
`timescale 1ns/1ps
// Dual-space access guard top. Judges processor and DMA requests in
// parallel and registers each verdict so it appears one clock after
// the request. Window bounds come from a lockable setup bank.
module space_guard
    import space_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_kernel,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic              cfg_lock,
    input  logic              cpu_valid,
    input  logic              cpu_space,
    input  logic [1:0]        cpu_access,
    input  logic              cpu_kernel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dma_valid,
    input  logic              dma_space,
    output logic              cpu_rsp_valid,
    output logic              cpu_rsp_grant,
    output logic              cpu_rsp_fault,
    output logic [2:0]        cpu_rsp_cause,
    output logic              dma_rsp_valid,
    output logic              dma_rsp_grant,
    output logic              dma_rsp_fault,
    output logic [2:0]        dma_rsp_cause
);

    logic [ADDR_W-1:0]  win_lo [WIN_CNT];
    logic [ADDR_W-1:0]  win_hi [WIN_CNT];
    logic               cfg_locked;
    logic [WIN_CNT-1:0] win_hit;
    verdict_t           cpu_verdict;
    verdict_t           dma_verdict;

    sg_window_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_kernel (cfg_kernel),
        .cfg_sel    (cfg_sel),
        .cfg_lo     (cfg_lo),
        .cfg_hi     (cfg_hi),
        .cfg_lock   (cfg_lock),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .locked     (cfg_locked)
    );

    sg_window_match #(.ADDR_W(ADDR_W)) u_match (
        .addr   (cpu_addr),
        .win_lo (win_lo),
        .win_hi (win_hi),
        .hit    (win_hit)
    );

    sg_cpu_rules u_cpu (
        .space   (cpu_space),
        .access  (cpu_access),
        .kernel  (cpu_kernel),
        .hit     (win_hit),
        .verdict (cpu_verdict)
    );

    sg_dma_rules u_dma (
        .space   (dma_space),
        .verdict (dma_verdict)
    );

    // Register the processor verdict; idle cycles give an all-zero response.
    always_ff @(posedge clk) begin
        if (!rst_n || !cpu_valid) begin
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_grant <= 1'b0;
            cpu_rsp_fault <= 1'b0;
            cpu_rsp_cause <= 3'd0;
        end else begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_grant <= cpu_verdict.grant;
            cpu_rsp_fault <= cpu_verdict.fault;
            cpu_rsp_cause <= cpu_verdict.cause;
        end
    end

    // Register the DMA verdict; idle cycles give an all-zero response.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_valid) begin
            dma_rsp_valid <= 1'b0;
            dma_rsp_grant <= 1'b0;
            dma_rsp_fault <= 1'b0;
            dma_rsp_cause <= 3'd0;
        end else begin
            dma_rsp_valid <= 1'b1;
            dma_rsp_grant <= dma_verdict.grant;
            dma_rsp_fault <= dma_verdict.fault;
            dma_rsp_cause <= dma_verdict.cause;
        end
    end

endmodule

// File: rtl/sg_checker.sv
`timescale 1ns/1ps
// Temporal checks for space_guard, attached by bind. Observes ports
// and the setup lock only.
module sg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_valid,
    input logic       cpu_space,
    input logic [1:0] cpu_access,
    input logic       cpu_kernel,
    input logic       dma_valid,
    input logic       dma_space,
    input logic       cpu_rsp_valid,
    input logic       cpu_rsp_grant,
    input logic       cpu_rsp_fault,
    input logic [2:0] cpu_rsp_cause,
    input logic       dma_rsp_valid,
    input logic       dma_rsp_grant,
    input logic       dma_rsp_fault,
    input logic [2:0] dma_rsp_cause,
    input logic       cfg_locked
);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |=> cpu_rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> (!cpu_rsp_valid && !cpu_rsp_grant && !cpu_rsp_fault));

    assert_data_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_space && cpu_access != 2'd0) |=> cpu_rsp_grant);

    assert_kern_dfetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_space && cpu_access == 2'd0 && cpu_kernel)
            |=> (cpu_rsp_fault && cpu_rsp_cause == 3'd3));

    assert_user_ispace_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_space && !cpu_kernel)
            |=> (cpu_rsp_fault && (cpu_rsp_cause == 3'd1 || cpu_rsp_cause == 3'd2)));

    assert_dma_ispace_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_space) |=> (dma_rsp_fault && dma_rsp_cause == 3'd4));

    assert_dma_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && dma_space) |=> (dma_rsp_grant && dma_rsp_valid));

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    assert_cpu_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rsp_grant, cpu_rsp_fault}) && (cpu_rsp_fault == (cpu_rsp_cause != 3'd0)));

    assert_dma_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_rsp_grant, dma_rsp_fault}) && (dma_rsp_fault == (dma_rsp_cause != 3'd0)));

endmodule

bind space_guard sg_checker u_sg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_space     (cpu_space),
    .cpu_access    (cpu_access),
    .cpu_kernel    (cpu_kernel),
    .dma_valid     (dma_valid),
    .dma_space     (dma_space),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_grant (cpu_rsp_grant),
    .cpu_rsp_fault (cpu_rsp_fault),
    .cpu_rsp_cause (cpu_rsp_cause),
    .dma_rsp_valid (dma_rsp_valid),
    .dma_rsp_grant (dma_rsp_grant),
    .dma_rsp_fault (dma_rsp_fault),
    .dma_rsp_cause (dma_rsp_cause),
    .cfg_locked    (cfg_locked)
);

// File: tb/tb_space_guard.sv
`timescale 1ns/1ps
// Bench for space_guard: a behavioural model of the window bounds and
// rules predicts both result ports and is compared on every clock.
module tb_space_guard;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_kernel = 1'b0, cfg_lock = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
    logic          cpu_valid = 1'b0, cpu_space = 1'b0, cpu_kernel = 1'b0;
    logic [1:0]    cpu_access = 2'd0;
    logic [AW-1:0] cpu_addr = '0;
    logic          dma_valid = 1'b0, dma_space = 1'b0;
    logic          cpu_rsp_valid, cpu_rsp_grant, cpu_rsp_fault;
    logic [2:0]    cpu_rsp_cause;
    logic          dma_rsp_valid, dma_rsp_grant, dma_rsp_fault;
    logic [2:0]    dma_rsp_cause;

    int  n_checks = 0;
    int  n_fail = 0;
    int  m_lo [3];
    int  m_hi [3];
    bit  m_locked;

    space_guard #(.ADDR_W(AW)) dut (.*);

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < 3; w++) begin
            m_lo[w] = (1 << AW) - 1;
            m_hi[w] = 0;
        end
        m_locked = 1'b0;
    endtask

    // Expected {valid,grant,fault,cause} for the processor port.
    function automatic int model_cpu(output string tag);
        int  a;
        bit  in_os, in_any, wr;
        a = int'(cpu_addr);
        if (!cpu_valid) begin tag = "R2"; return 0; end
        in_os  = a >= m_lo[0] && a <= m_hi[0];
        in_any = in_os || (a >= m_lo[1] && a <= m_hi[1]) || (a >= m_lo[2] && a <= m_hi[2]);
        wr = cpu_access >= 2'd2;
        if (cpu_space) begin
            if (cpu_access == 2'd0 && cpu_kernel) begin tag = "R4"; return 'h2B; end
            tag = "R3"; return 'h30;
        end
        if (wr && in_os)  begin tag = "R5"; return 'h29; end
        if (!cpu_kernel)  begin tag = "R6"; return 'h2A; end
        if (!in_any)      begin tag = "R8"; return 'h2D; end
        tag = "R7"; return 'h30;
    endfunction

    function automatic int model_dma(output string tag);
        tag = "R9";
        if (!dma_valid) begin tag = "R2"; return 0; end
        return dma_space ? 'h30 : 'h2C;
    endfunction

    // One clock: predict, advance the model's setup state (R10), compare.
    task automatic step();
        string ct, dt;
        int    ce, de, ca, da;
        bit    open_w;
        ce = model_cpu(ct);
        de = model_dma(dt);
        open_w = cfg_kernel && !m_locked;
        if (cfg_we && open_w && cfg_sel < 2'd3) begin
            m_lo[cfg_sel] = int'(cfg_lo);
            m_hi[cfg_sel] = int'(cfg_hi);
        end
        if (cfg_lock && open_w) m_locked = 1'b1;
        @(posedge clk);
        #1;
        ca = int'({cpu_rsp_valid, cpu_rsp_grant, cpu_rsp_fault, cpu_rsp_cause});
        da = int'({dma_rsp_valid, dma_rsp_grant, dma_rsp_fault, dma_rsp_cause});
        check(ca == ce, {"cpu ", ct}, ca, ce);
        check(da == de, {"dma ", dt}, da, de);
        // R11: grant and fault exclusive on both ports
        check(!(cpu_rsp_grant && cpu_rsp_fault) && !(dma_rsp_grant && dma_rsp_fault),
              "R11 exclusive", ca, ce);
    endtask

    task automatic idle_inputs();
        cfg_we = 1'b0; cfg_lock = 1'b0; cfg_kernel = 1'b0;
        cpu_valid = 1'b0; dma_valid = 1'b0;
    endtask

    task automatic cpu_req(input bit sp, input logic [1:0] ac, input bit k, input int a);
        idle_inputs();
        cpu_valid = 1'b1; cpu_space = sp; cpu_access = ac; cpu_kernel = k;
        cpu_addr = AW'(a);
        step();
    endtask

    task automatic set_win(input bit k, input logic [1:0] sel, input int lo, input int hi, input bit lk);
        idle_inputs();
        cfg_we = 1'b1; cfg_kernel = k; cfg_sel = sel;
        cfg_lo = AW'(lo); cfg_hi = AW'(hi); cfg_lock = lk;
        step();
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            int pick;
            idle_inputs();
            cpu_valid  = ($urandom % 4) != 0;
            cpu_space  = 1'($urandom);
            cpu_access = 2'($urandom);
            cpu_kernel = 1'($urandom);
            pick = int'($urandom % 8);
            case (pick)
                0: cpu_addr = AW'(m_lo[0]);
                1: cpu_addr = AW'(m_hi[1]);
                2: cpu_addr = AW'(m_hi[1] + 1);
                3: cpu_addr = AW'(m_lo[2] - 1);
                4: cpu_addr = AW'(m_lo[2]);
                default: cpu_addr = AW'($urandom);
            endcase
            dma_valid = 1'($urandom);
            dma_space = 1'($urandom);
            step();
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        check({cpu_rsp_valid, cpu_rsp_grant, cpu_rsp_fault, cpu_rsp_cause,
               dma_rsp_valid, dma_rsp_grant, dma_rsp_fault, dma_rsp_cause} == '0,
              "R1 reset outputs", 1, 0);
        rst_n = 1'b1;
        idle_inputs();
        step();
        // R1: empty windows after reset
        cpu_req(1'b0, 2'd1, 1'b1, 'h0000);
        cpu_req(1'b0, 2'd1, 1'b1, 'hFFFF);

        // R10: user-level setup write is ignored
        set_win(1'b0, 2'd0, 'h0100, 'h01FF, 1'b0);
        cpu_req(1'b0, 2'd2, 1'b1, 'h0150);
        // R10: user-level lock is ignored, later kernel writes still land
        set_win(1'b0, 2'd3, 0, 0, 1'b1);
        set_win(1'b1, 2'd0, 'h0100, 'h01FF, 1'b0);
        set_win(1'b1, 2'd1, 'h0800, 'h08FF, 1'b0);
        set_win(1'b1, 2'd2, 'hF000, 'hF0FF, 1'b0);

        // R5: locked window writes, bounds inclusive
        cpu_req(1'b0, 2'd2, 1'b1, 'h0100);
        cpu_req(1'b0, 2'd2, 1'b1, 'h01FF);
        cpu_req(1'b0, 2'd3, 1'b1, 'h0180);
        cpu_req(1'b0, 2'd2, 1'b0, 'h0150);
        // R8: just outside the windows
        cpu_req(1'b0, 2'd2, 1'b1, 'h0200);
        cpu_req(1'b0, 2'd1, 1'b1, 'h00FF);
        cpu_req(1'b0, 2'd1, 1'b1, 'h0900);
        // R7: kernel access inside windows
        cpu_req(1'b0, 2'd1, 1'b1, 'h0100);
        cpu_req(1'b0, 2'd0, 1'b1, 'h0150);
        cpu_req(1'b0, 2'd2, 1'b1, 'h08FF);
        cpu_req(1'b0, 2'd2, 1'b1, 'hF000);
        cpu_req(1'b0, 2'd0, 1'b1, 'hF0FF);
        // R6: user access to instruction space
        cpu_req(1'b0, 2'd1, 1'b0, 'h0150);
        cpu_req(1'b0, 2'd0, 1'b0, 'h0800);
        cpu_req(1'b0, 2'd2, 1'b0, 'hF000);
        // R3 and R4: data space
        cpu_req(1'b1, 2'd0, 1'b1, 'h1234);
        cpu_req(1'b1, 2'd0, 1'b0, 'h1234);
        cpu_req(1'b1, 2'd2, 1'b0, 'h0150);
        cpu_req(1'b1, 2'd1, 1'b1, 'hF000);
        // R9: DMA alongside processor traffic
        idle_inputs();
        cpu_valid = 1'b1; cpu_space = 1'b0; cpu_access = 2'd1; cpu_kernel = 1'b1;
        cpu_addr = 'h0800; dma_valid = 1'b1; dma_space = 1'b0;
        step();
        idle_inputs();
        cpu_valid = 1'b1; cpu_space = 1'b1; cpu_access = 2'd0; cpu_kernel = 1'b1;
        dma_valid = 1'b1; dma_space = 1'b1;
        step();
        idle_inputs();
        dma_valid = 1'b1; dma_space = 1'b0;
        step();

        random_run(300);

        // R10: lock in the same cycle as a write; the write lands
        set_win(1'b1, 2'd1, 'h0A00, 'h0AFF, 1'b1);
        cpu_req(1'b0, 2'd2, 1'b1, 'h0A00);
        cpu_req(1'b0, 2'd2, 1'b1, 'h0800);
        // R10: writes after the lock are ignored
        set_win(1'b1, 2'd0, 'h3000, 'h30FF, 1'b0);
        cpu_req(1'b0, 2'd2, 1'b1, 'h3000);
        cpu_req(1'b0, 2'd2, 1'b1, 'h0100);
        set_win(1'b1, 2'd2, 'h0000, 'hFFFF, 1'b0);
        cpu_req(1'b0, 2'd1, 1'b1, 'h5000);

        random_run(300);

        // R1: reset reopens the bank and empties the windows
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_reset();
        rst_n = 1'b1;
        cpu_req(1'b0, 2'd1, 1'b1, 'h0100);
        set_win(1'b1, 2'd0, 'h0100, 'h01FF, 1'b0);
        cpu_req(1'b0, 2'd1, 1'b1, 'h0100);
        idle_inputs();
        step();
        finish_run();
    end

endmodule